// File: doc/BRIEF.md
# Oscillator Divider Pair Search Engine

This block takes a requested output frequency in hertz and finds a legal setting for the two cascaded output dividers of a programmable oscillator. The internal oscillator runs at the output frequency multiplied by both dividers. That product must fall inside the oscillator's allowed band. Of all legal pairs that meet this band, the block keeps the one that gives the lowest oscillator frequency, because a lower oscillator frequency draws less power. If two pairs give the same product, it keeps the one with the smaller output divider.

A start pulse captures the frequency request. The search then tries one candidate pair per clock and always takes the same number of cycles. At the end a single-cycle done pulse is raised. With it the block reports the chosen dividers, both as plain values and as register codes, together with the oscillator frequency that results. The block that computes the fractional multiplier downstream uses that oscillator frequency. When no pair can reach the band, an error flag is raised with done and all result outputs read zero.

Top module: `divider_pair_search`

## Requirements
- R1: The high-speed divider reported on `hs_div` is one of 4, 5, 6, 7, 9, 11 and `hs_code` equals that value minus 4 (3 bits: 4→0, 5→1, 6→2, 7→3, 9→5, 11→7).
- R2: The output divider reported on `n1_div` is 1 or an even number from 2 to 128, and `n1_code` equals that value minus 1 (7 bits).
- R3: On a successful result, `dco_hz` equals `fout_hz × hs_div × n1_div` and lies within 4 850 000 000 to 5 670 000 000 Hz, with both ends allowed.
- R4: The chosen pair gives the smallest in-band oscillator frequency over all legal pairs.
- R5: When several legal pairs give the same smallest product, the pair with the smallest `n1_div` (and so the largest `hs_div`) is chosen.
- R6: When no legal pair lands in the band, `err` is 1 during the done pulse and `hs_div`, `hs_code`, `n1_div`, `n1_code` and `dco_hz` are all zero. `err` is 0 with every successful result.
- R7: `done` is a one-cycle pulse seen right after the 392nd rising edge that follows the edge sampling `start`. `busy` is 1 from the edge after `start` until done rises, and it is 0 while done is high.
- R8: A `start` while `busy` is 1 is ignored. The search in progress keeps its captured frequency and its completion time.
- R9: After reset, `busy`, `done`, `err` and all result outputs are zero.
- R10: Result outputs and `err` hold their values after done until the next search completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search with the current `fout_hz` (ignored while busy) |
| fout_hz | input | 32 | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No legal pair reaches the oscillator band |
| hs_div | output | 4 | Chosen high-speed divider value |
| hs_code | output | 3 | High-speed divider register code (value − 4) |
| n1_div | output | 8 | Chosen output divider value |
| n1_code | output | 7 | Output divider register code (value − 1) |
| dco_hz | output | 44 | Resulting oscillator frequency in Hz |

## Verification
Every fault inside the search shows up at the ports at the single done pulse of that search, 392 edges after start, and nowhere before it. A candidate counter that skips or repeats entries shows up as a later or earlier done, or as a pair that is not the minimum for a request whose answer needs a large output divider. A wrong comparison in the best-pair tracker shows up as a higher oscillator frequency, or as the larger-N1 pair in a tie. A wrong band check shows up at the exact band edges, where one extra hertz has to flip the result to an error. The request table therefore holds tie cases, both inclusive band edges, requests just outside the band edges, and requests that need the largest output dividers.

// File: rtl/divsel_pkg.sv
package divsel_pkg;
  localparam int HS_NUM   = 6;
  localparam int HS_IDX_W = 3;
  localparam int HS_W     = 4;

  // Search order: largest high-speed divider first, so within one N1 the
  // candidates come in descending product order.
  function automatic logic [HS_W-1:0] hs_from_idx(input logic [HS_IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 4'd11;
      3'd1:    return 4'd9;
      3'd2:    return 4'd7;
      3'd3:    return 4'd6;
      3'd4:    return 4'd5;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic hs_is_legal(input logic [HS_W-1:0] v);
    return (v == 4'd4) || (v == 4'd5) || (v == 4'd6) ||
           (v == 4'd7) || (v == 4'd9) || (v == 4'd11);
  endfunction
endpackage

// File: rtl/divsel_cand_gen.sv
module divsel_cand_gen
  import divsel_pkg::*;
#(
  parameter int N1_MAX = 128,
  localparam int NUM_N1   = N1_MAX / 2 + 1,
  localparam int N1_IDX_W = $clog2(NUM_N1),
  localparam int N1_W     = $clog2(N1_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  output logic            cand_valid,
  output logic            cand_last,
  output logic [HS_W-1:0] cand_hs,
  output logic [N1_W-1:0] cand_n1
);
  logic [HS_IDX_W-1:0] hs_i;
  logic [N1_IDX_W-1:0] n1_i;
  logic                active;
  logic                hs_wrap;
  logic                n1_end;

  assign hs_wrap = (hs_i == HS_IDX_W'(HS_NUM - 1));
  assign n1_end  = (n1_i == N1_IDX_W'(NUM_N1 - 1));

  // N1 is the outer loop (ascending), the high-speed divider the inner one.
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hs_i   <= '0;
      n1_i   <= '0;
    end else if (launch) begin
      active <= 1'b1;
      hs_i   <= '0;
      n1_i   <= '0;
    end else if (active) begin
      if (hs_wrap) begin
        hs_i <= '0;
        if (n1_end) active <= 1'b0;
        else        n1_i   <= n1_i + N1_IDX_W'(1);
      end else begin
        hs_i <= hs_i + HS_IDX_W'(1);
      end
    end
  end

  assign cand_valid = active;
  assign cand_last  = active & hs_wrap & n1_end;
  assign cand_hs    = hs_from_idx(hs_i);
  assign cand_n1    = (n1_i == '0) ? N1_W'(1) : N1_W'({n1_i, 1'b0});

  AST_CAND_HS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> hs_is_legal(cand_hs)); // R1
endmodule

// File: rtl/divsel_mult.sv
module divsel_mult
  import divsel_pkg::*;
#(
  parameter int FOUT_W = 32,
  parameter int N1_W   = 8,
  parameter int PROD_W = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [FOUT_W-1:0] in_fout,
  input  logic [HS_W-1:0]   in_hs,
  input  logic [N1_W-1:0]   in_n1,
  output logic              p_valid,
  output logic              p_last,
  output logic [HS_W-1:0]   p_hs,
  output logic [N1_W-1:0]   p_n1,
  output logic [PROD_W-1:0] p_dco
);
  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_last  <= 1'b0;
      p_hs    <= '0;
      p_n1    <= '0;
      p_dco   <= '0;
    end else begin
      p_valid <= in_valid;
      p_last  <= in_valid & in_last;
      p_hs    <= in_hs;
      p_n1    <= in_n1;
      p_dco   <= PROD_W'(in_fout) * PROD_W'(in_hs) * PROD_W'(in_n1);
    end
  end
endmodule

// File: rtl/divsel_best.sv
module divsel_best
  import divsel_pkg::*;
#(
  parameter int          N1_W       = 8,
  parameter int          N1_MAX     = 128,
  parameter int          PROD_W     = 44,
  parameter logic [63:0] DCO_MIN_HZ = 64'd4_850_000_000,
  parameter logic [63:0] DCO_MAX_HZ = 64'd5_670_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [HS_W-1:0]   in_hs,
  input  logic [N1_W-1:0]   in_n1,
  input  logic [PROD_W-1:0] in_dco,
  output logic              found,
  output logic [HS_W-1:0]   best_hs,
  output logic [N1_W-1:0]   best_n1,
  output logic [PROD_W-1:0] best_dco,
  output logic              fin
);
  localparam logic [PROD_W-1:0] LO_T = PROD_W'(DCO_MIN_HZ);
  localparam logic [PROD_W-1:0] HI_T = PROD_W'(DCO_MAX_HZ);

  logic in_band;
  logic better;

  assign in_band = (in_dco >= LO_T) && (in_dco <= HI_T);
  // Strict compare: candidates arrive with N1 ascending, so the first of
  // equal products (smallest N1) is the one kept.
  assign better  = in_valid && in_band && (!found || (in_dco < best_dco));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found    <= 1'b0;
      best_hs  <= '0;
      best_n1  <= '0;
      best_dco <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= in_valid & in_last;
      if (better) begin
        found    <= 1'b1;
        best_hs  <= in_hs;
        best_n1  <= in_n1;
        best_dco <= in_dco;
      end
    end
  end

  AST_BEST_HS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    found |-> hs_is_legal(best_hs)); // R1
  AST_BEST_N1_LEGAL: assert property (@(posedge clk) disable iff (rst)
    found |-> ((best_n1 == N1_W'(1)) ||
               (!best_n1[0] && best_n1 != '0 && best_n1 <= N1_W'(N1_MAX)))); // R2
  AST_BEST_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (found && $past(found) && !$past(clear)) |-> (best_dco <= $past(best_dco))); // R4
endmodule

// File: rtl/divider_pair_search.sv
module divider_pair_search
  import divsel_pkg::*;
#(
  parameter int          FOUT_W     = 32,
  parameter int          N1_MAX     = 128,
  parameter logic [63:0] DCO_MIN_HZ = 64'd4_850_000_000,
  parameter logic [63:0] DCO_MAX_HZ = 64'd5_670_000_000,
  localparam int N1_W   = $clog2(N1_MAX + 1),
  localparam int PROD_W = FOUT_W + HS_W + N1_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FOUT_W-1:0] fout_hz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [HS_W-1:0]   hs_div,
  output logic [HS_IDX_W-1:0] hs_code,
  output logic [N1_W-1:0]   n1_div,
  output logic [N1_W-2:0]   n1_code,
  output logic [PROD_W-1:0] dco_hz
);
  logic              launch;
  logic [FOUT_W-1:0] fout_q;

  logic              c_valid, c_last;
  logic [HS_W-1:0]   c_hs;
  logic [N1_W-1:0]   c_n1;

  logic              m_valid, m_last;
  logic [HS_W-1:0]   m_hs;
  logic [N1_W-1:0]   m_n1;
  logic [PROD_W-1:0] m_dco;

  logic              b_found, b_fin;
  logic [HS_W-1:0]   b_hs;
  logic [N1_W-1:0]   b_n1;
  logic [PROD_W-1:0] b_dco;

  assign launch = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst)         fout_q <= '0;
    else if (launch) fout_q <= fout_hz;
  end

  divsel_cand_gen #(.N1_MAX(N1_MAX)) u_gen (
    .clk(clk), .rst(rst), .launch(launch),
    .cand_valid(c_valid), .cand_last(c_last), .cand_hs(c_hs), .cand_n1(c_n1)
  );

  divsel_mult #(.FOUT_W(FOUT_W), .N1_W(N1_W), .PROD_W(PROD_W)) u_mult (
    .clk(clk), .rst(rst),
    .in_valid(c_valid), .in_last(c_last), .in_fout(fout_q),
    .in_hs(c_hs), .in_n1(c_n1),
    .p_valid(m_valid), .p_last(m_last), .p_hs(m_hs), .p_n1(m_n1), .p_dco(m_dco)
  );

  divsel_best #(
    .N1_W(N1_W), .N1_MAX(N1_MAX), .PROD_W(PROD_W),
    .DCO_MIN_HZ(DCO_MIN_HZ), .DCO_MAX_HZ(DCO_MAX_HZ)
  ) u_best (
    .clk(clk), .rst(rst), .clear(launch),
    .in_valid(m_valid), .in_last(m_last),
    .in_hs(m_hs), .in_n1(m_n1), .in_dco(m_dco),
    .found(b_found), .best_hs(b_hs), .best_n1(b_n1), .best_dco(b_dco),
    .fin(b_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      hs_div  <= '0;
      hs_code <= '0;
      n1_div  <= '0;
      n1_code <= '0;
      dco_hz  <= '0;
    end else begin
      done <= b_fin;
      if (launch)     busy <= 1'b1;
      else if (b_fin) busy <= 1'b0;
      if (b_fin) begin
        err <= ~b_found;
        if (b_found) begin
          hs_div  <= b_hs;
          hs_code <= HS_IDX_W'(b_hs - HS_W'(4));
          n1_div  <= b_n1;
          n1_code <= (N1_W-1)'(b_n1 - N1_W'(1));
          dco_hz  <= b_dco;
        end else begin
          hs_div  <= '0;
          hs_code <= '0;
          n1_div  <= '0;
          n1_code <= '0;
          dco_hz  <= '0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_RESULT_IN_BAND: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((dco_hz >= PROD_W'(DCO_MIN_HZ)) && (dco_hz <= PROD_W'(DCO_MAX_HZ)))); // R3
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (hs_div == '0 && n1_div == '0 && dco_hz == '0)); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(!b_fin)) |-> ($stable(dco_hz) && $stable(err))); // R10
endmodule

// File: tb/sim_divider_pair_search.sv
module sim_divider_pair_search;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 392;

  typedef struct packed {
    logic [31:0] fout;
    logic        err;
    logic [3:0]  hs;
    logic [7:0]  n1;
    logic [43:0] dco;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'd56_320_000,    1'b0, 4'd11, 8'd8,   44'd4_956_160_000}, // R5 tie 11x8 vs 4x22
    '{32'd10_000_000,    1'b0, 4'd9,  8'd54,  44'd4_860_000_000},
    '{32'd160_000_000,   1'b0, 4'd4,  8'd8,   44'd5_120_000_000},
    '{32'd1_000_000_000, 1'b0, 4'd5,  8'd1,   44'd5_000_000_000},
    '{32'd5_000_000,     1'b0, 4'd9,  8'd108, 44'd4_860_000_000},
    '{32'd48_500_000,    1'b0, 4'd5,  8'd20,  44'd4_850_000_000}, // lower edge
    '{32'd1_417_500_000, 1'b0, 4'd4,  8'd1,   44'd5_670_000_000}, // upper edge
    '{32'd1_212_500_000, 1'b0, 4'd4,  8'd1,   44'd4_850_000_000},
    '{32'd81_000_000,    1'b0, 4'd6,  8'd10,  44'd4_860_000_000}, // R5 tie 6x10 vs 5x12
    '{32'd1_417_500_001, 1'b1, 4'd0,  8'd0,   44'd0},
    '{32'd1_212_499_999, 1'b1, 4'd0,  8'd0,   44'd0},
    '{32'd100,           1'b1, 4'd0,  8'd0,   44'd0},
    '{32'd3_000_000_000, 1'b1, 4'd0,  8'd0,   44'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] fout_hz = '0;
  logic        busy, done, err;
  logic [3:0]  hs_div;
  logic [2:0]  hs_code;
  logic [7:0]  n1_div;
  logic [6:0]  n1_code;
  logic [43:0] dco_hz;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divider_pair_search u0 (
    .clk(clk), .rst(rst), .start(start), .fout_hz(fout_hz),
    .busy(busy), .done(done), .err(err),
    .hs_div(hs_div), .hs_code(hs_code), .n1_div(n1_div), .n1_code(n1_code),
    .dco_hz(dco_hz)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Exhaustive search written straight from the selection rules.
  task automatic ref_pick(input logic [31:0] f, output logic e, output logic [3:0] h,
                          output logic [7:0] n, output logic [43:0] d);
    int hsv [6] = '{4, 5, 6, 7, 9, 11};
    longint best = 0;
    int bh = 0, bn = 0;
    bit got = 0;
    for (int i = 0; i < 6; i++) begin
      for (int k = 1; k <= 128; k++) begin
        longint p;
        if (k != 1 && (k % 2) != 0) continue;
        p = longint'(f) * hsv[i] * k;
        if (p >= 64'd4_850_000_000 && p <= 64'd5_670_000_000) begin
          if (!got || p < best || (p == best && k < bn)) begin
            got = 1; best = p; bh = hsv[i]; bn = k;
          end
        end
      end
    end
    e = !got;
    h = 4'(bh);
    n = 8'(bn);
    d = 44'(best);
  endtask

  task automatic run_one(input logic [31:0] f, output int lat);
    @(negedge clk);
    fout_hz = f;
    start   = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(posedge clk);
      #1;
      lat++;
    end
  endtask

  task automatic check_result(input logic e, input logic [3:0] h, input logic [7:0] n,
                              input logic [43:0] d, input int lat);
    chk("R7", "latency", 64'(lat), 64'(LATENCY));
    chk("R6", "err", 64'(err), 64'(e));
    chk("R1", "hs_div", 64'(hs_div), 64'(h));
    chk("R1", "hs_code", 64'(hs_code), e ? 64'd0 : 64'(h - 4'd4));
    chk("R2", "n1_div", 64'(n1_div), 64'(n));
    chk("R2", "n1_code", 64'(n1_code), e ? 64'd0 : 64'(n - 8'd1));
    chk("R4", "dco_hz", 64'(dco_hz), 64'(d));
    if (!e) chk("R3", "dco product", 64'(dco_hz),
                64'(fout_hz) * 64'(hs_div) * 64'(n1_div));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lat;
    logic e;
    logic [3:0] h;
    logic [7:0] n;
    logic [43:0] d;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "busy", 64'(busy), 0);
    chk("R9", "done", 64'(done), 0);
    chk("R9", "err", 64'(err), 0);
    chk("R9", "hs_div", 64'(hs_div), 0);
    chk("R9", "n1_div", 64'(n1_div), 0);
    chk("R9", "dco_hz", 64'(dco_hz), 0);

    // Table of requests with hand-derived expectations (R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      run_one(VECS[i].fout, lat);
      check_result(VECS[i].err, VECS[i].hs, VECS[i].n1, VECS[i].dco, lat);
    end

    // Extra requests against the exhaustive model (R4 R5)
    begin
      logic [31:0] extra [5] = '{32'd7_123_457, 32'd25_000_000, 32'd300_000_000,
                                 32'd14_074_000, 32'd550_000_000};
      for (int i = 0; i < 5; i++) begin
        ref_pick(extra[i], e, h, n, d);
        run_one(extra[i], lat);
        check_result(e, h, n, d, lat);
      end
    end

    // R7 busy window and R8 start ignored while busy
    @(negedge clk);
    fout_hz = 32'd56_320_000;
    start   = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    chk("R7", "busy after start", 64'(busy), 1);
    repeat (50) begin @(posedge clk); #1; lat++; end
    chk("R7", "busy mid run", 64'(busy), 1);
    @(negedge clk);
    fout_hz = 32'd160_000_000;
    start   = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat++;
    while (!done && lat < 2000) begin @(posedge clk); #1; lat++; end
    chk("R8", "latency unchanged", 64'(lat), 64'(LATENCY));
    chk("R8", "hs_div of first request", 64'(hs_div), 11);
    chk("R8", "n1_div of first request", 64'(n1_div), 8);
    chk("R8", "dco of first request", 64'(dco_hz), 64'd4_956_160_000);
    chk("R7", "busy low at done", 64'(busy), 0);

    // R7 single-cycle pulse, R10 hold
    @(posedge clk);
    #1;
    chk("R7", "done pulse ends", 64'(done), 0);
    fout_hz = 32'd100;
    repeat (20) @(posedge clk);
    #1;
    chk("R10", "hs_div held", 64'(hs_div), 11);
    chk("R10", "n1_code held", 64'(n1_code), 7);
    chk("R10", "dco held", 64'(dco_hz), 64'd4_956_160_000);
    chk("R10", "err held", 64'(err), 0);
    chk("R10", "busy idle", 64'(busy), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule